// File: doc/BRIEF.md
# Two-Epoch Speculative Verification Tracker

This block sits inside a secure memory controller. Data may go back to the caches before its integrity check finishes. The block counts those speculative returns in one of two alternating epochs. Each return is tagged with the epoch that is active when it arrives, and that tag is kept per outstanding load. Verification results may arrive in any order. Each result retires its load against the epoch recorded for it. When an epoch's count of pending checks falls to zero, the block pulses a clear for that epoch alone, so structures elsewhere can drop that epoch's poison bits in one step.

Outgoing demand requests enter a small slot queue together with a two-bit poison mask, one bit per epoch. A poisoned request stays in the queue until every epoch named in its mask has been cleared. Uncached or IO requests wait until nothing at all is pending. Released demand requests share the memory port with verification metadata fetches. A failed integrity check raises a sticky halt that silences the memory port.

Top module: `spec_verif_tracker`

## Requirements
- R1: After reset the active epoch is 0, halt is low, both clear pulses are low, the memory port is idle and the request queue accepts entries.
- R2: A speculative return is tagged with the active epoch (`ret_epoch` equals `active_epoch` in that cycle) and raises that epoch's pending count by one.
- R3: A verification result lowers the pending count of the epoch recorded for its tag, whichever epoch is active now; results may complete in an order different from the returns.
- R4: When an epoch's pending count falls from nonzero to zero, `epoch_clr` bit e (bit 0 = epoch 0, bit 1 = epoch 1) is high for exactly one cycle, in the cycle after the result is presented; the other bit stays low.
- R5: The active epoch flips once it has been open for MIN_DUR cycles and the other epoch has no pending checks. After reset with nothing pending, the first flip is visible after the 9th rising edge when MIN_DUR = 8.
- R6: If the minimum duration has elapsed but the other epoch still has pending checks, the active epoch does not change and keeps taking new returns.
- R7: A queued request whose poison mask has bit e set (bit e = epoch e) is not issued until epoch e has been cleared for every set bit. A clear pulse takes effect on the queue at the next edge. Among eligible entries, the lowest slot issues first.
- R8: A request marked IO is not issued while either epoch has pending checks, even if its own poison mask is zero.
- R9: When both an eligible demand request and a metadata request are waiting, the demand request wins, unless `meta_full` is high, in which case the metadata request wins.
- R10: A verification result with `vd_ok` low sets `halt` from the next cycle onward, permanently until reset, and while `halt` is high `mem_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ret_valid | input | 1 | Unverified data returned this cycle |
| ret_tag | input | TAG_W | Identifier of the returning load |
| ret_epoch | output | 1 | Epoch assigned to the current return |
| vd_valid | input | 1 | Verification result valid |
| vd_tag | input | TAG_W | Load identifier of the result |
| vd_ok | input | 1 | Integrity check passed |
| epoch_clr | output | 2 | One-cycle per-epoch poison clear |
| active_epoch | output | 1 | Epoch currently open |
| halt | output | 1 | Sticky integrity failure |
| rq_valid | input | 1 | New outgoing demand request |
| rq_addr | input | ADDR_W | Request address |
| rq_poison | input | 2 | Poison mask, bit e = epoch e |
| rq_io | input | 1 | Uncached or IO request |
| rq_ready | output | 1 | Queue has a free slot |
| meta_valid | input | 1 | Metadata fetch waiting |
| meta_addr | input | ADDR_W | Metadata address |
| meta_full | input | 1 | Metadata queue full, raise its priority |
| meta_ready | output | 1 | Metadata fetch taken this cycle |
| mem_valid | output | 1 | Request offered to memory |
| mem_addr | output | ADDR_W | Offered address |
| mem_is_meta | output | 1 | Offered request is metadata |
| mem_ready | input | 1 | Memory accepts the offer |

## Verification
A counter charged to the wrong epoch shows up as a clear pulse on the wrong `epoch_clr` bit, or as a missing one, one cycle after the deciding result. A held request then issues too early or stays stuck on `mem_valid` one cycle after that. A poison mask that is not flash-cleared keeps `mem_valid` low after the pulse. A mask that is cleared too broadly lets a request carrying the other epoch's bit onto the port at once. A wrong timer or drain test moves the cycle in which `active_epoch` flips, and with it the epoch that `ret_epoch` reports for the next return.

// File: rtl/spt_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the speculative verification tracker.
package spt_pkg;
    localparam int unsigned NUM_EPOCHS = 2;
    typedef logic [NUM_EPOCHS-1:0] epoch_mask_t;
endpackage

// File: rtl/spt_tag_table.sv
`timescale 1ns/1ps
// Per-load record of the epoch a speculative return was charged to.
// Assumes a tag is not reissued while still outstanding and that every
// verification result names an outstanding tag.
module spt_tag_table #(
    parameter int unsigned TAG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_valid,
    input  logic [TAG_W-1:0] set_tag,
    input  logic             set_epoch,
    input  logic             look_valid,
    input  logic [TAG_W-1:0] look_tag,
    output logic             look_hit,
    output logic             look_epoch
);
    localparam int unsigned NTAG = 1 << TAG_W;

    logic pend_q [NTAG];
    logic ep_q   [NTAG];

    // Record the epoch on return, retire the entry on its result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NTAG; i++) begin
                pend_q[i] <= 1'b0;
                ep_q[i]   <= 1'b0;
            end
        end else begin
            for (int i = 0; i < NTAG; i++) begin
                if (set_valid && set_tag == TAG_W'(i)) begin
                    pend_q[i] <= 1'b1;
                    ep_q[i]   <= set_epoch;
                end else if (look_valid && look_tag == TAG_W'(i)) begin
                    pend_q[i] <= 1'b0;
                end
            end
        end
    end

    // Look up the stored epoch for the result being retired.
    always_comb begin
        look_hit   = pend_q[look_tag];
        look_epoch = ep_q[look_tag];
    end

    p_result_known_r3: assert property (@(posedge clk) disable iff (!rst_n)
        look_valid |-> look_hit);
    p_tag_not_reused_r2: assert property (@(posedge clk) disable iff (!rst_n)
        set_valid |-> (!pend_q[set_tag] || (look_valid && look_tag == set_tag)));
endmodule

// File: rtl/spt_epoch_ctrl.sv
`timescale 1ns/1ps
// Pending counters for both epochs, the minimum-duration timer that
// flips the active epoch, the per-epoch clear pulse and the halt flag.
// Assumes MIN_DUR >= 1 and CNT_W wide enough for every outstanding tag.
module spt_epoch_ctrl
    import spt_pkg::*;
#(
    parameter int unsigned CNT_W   = 5,
    parameter int unsigned MIN_DUR = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        inc,
    input  logic        dec_valid,
    input  logic        dec_epoch,
    input  logic        fail,
    output logic        cur_epoch,
    output epoch_mask_t clr,
    output logic        any_pending,
    output logic        halt
);
    localparam int unsigned TMR_W = $clog2(MIN_DUR + 1);
    localparam logic [TMR_W-1:0] TMR_MAX = TMR_W'(MIN_DUR);

    logic [NUM_EPOCHS-1:0][CNT_W-1:0] cnt_q, cnt_d;
    epoch_mask_t      inc_e, dec_e, clr_q;
    logic             cur_q, halt_q, switch_now;
    logic [TMR_W-1:0] tmr_q;

    // Next value of each epoch's pending count.
    always_comb begin
        for (int e = 0; e < NUM_EPOCHS; e++) begin
            inc_e[e] = inc && (cur_q == 1'(e));
            dec_e[e] = dec_valid && (dec_epoch == 1'(e));
            cnt_d[e] = cnt_q[e];
            if (inc_e[e] && !dec_e[e])
                cnt_d[e] = cnt_q[e] + CNT_W'(1);
            else if (!inc_e[e] && dec_e[e])
                cnt_d[e] = cnt_q[e] - CNT_W'(1);
        end
    end

    // Flip only after the minimum time and once the other epoch is drained.
    always_comb switch_now = (tmr_q == TMR_MAX) && (cnt_q[~cur_q] == '0);

    // Counters, drain pulses, timer, active epoch and halt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            clr_q  <= '0;
            cur_q  <= 1'b0;
            tmr_q  <= '0;
            halt_q <= 1'b0;
        end else begin
            for (int e = 0; e < NUM_EPOCHS; e++) begin
                cnt_q[e] <= cnt_d[e];
                clr_q[e] <= (cnt_q[e] != '0) && (cnt_d[e] == '0);
            end
            if (switch_now) begin
                cur_q <= ~cur_q;
                tmr_q <= '0;
            end else if (tmr_q != TMR_MAX) begin
                tmr_q <= tmr_q + TMR_W'(1);
            end
            halt_q <= halt_q | fail;
        end
    end

    always_comb begin
        cur_epoch   = cur_q;
        clr         = clr_q;
        halt        = halt_q;
        any_pending = (cnt_q[0] != '0) || (cnt_q[1] != '0);
    end

    p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !(inc && cur_q == dec_epoch)) |-> (cnt_q[dec_epoch] != '0));
    p_clr_single_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_q != '0) |=> ((clr_q & $past(clr_q)) == '0));
    p_flip_into_drained_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q != $past(cur_q)) |-> ($past(cnt_q[~cur_q]) == '0));
    p_stay_open_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_q == TMR_MAX && cnt_q[~cur_q] != '0) |=> (cur_q == $past(cur_q)));
    p_halt_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        halt_q |=> halt_q);
endmodule

// File: rtl/spt_hold_queue.sv
`timescale 1ns/1ps
// Slot queue for outgoing demand requests. Each slot keeps a poison mask
// that is flash-cleared per epoch. A slot is eligible once its mask is
// empty (IO slots also need no pending checks); the lowest eligible slot
// is offered. Assumes the downstream acknowledges only the offered slot.
module spt_hold_queue
    import spt_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DEPTH  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enq_valid,
    input  logic [ADDR_W-1:0] enq_addr,
    input  epoch_mask_t       enq_poison,
    input  logic              enq_io,
    output logic              enq_ready,
    input  epoch_mask_t       clr,
    input  logic              any_pending,
    output logic              iss_valid,
    output logic [ADDR_W-1:0] iss_addr,
    input  logic              iss_ack
);
    localparam int unsigned IDX_W = $clog2(DEPTH);

    logic [DEPTH-1:0]  vld_q, io_q, elig;
    epoch_mask_t       poison_q [DEPTH];
    logic [ADDR_W-1:0] addr_q   [DEPTH];
    logic [IDX_W-1:0]  free_idx, iss_idx;
    logic              enq_fire, iss_fire;

    // Per-slot eligibility to leave the chip.
    for (genvar g = 0; g < DEPTH; g++) begin : g_elig
        assign elig[g] = vld_q[g] && (poison_q[g] == '0) && (!io_q[g] || !any_pending);
    end

    // Lowest free slot and lowest eligible slot.
    always_comb begin
        free_idx  = '0;
        iss_idx   = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!vld_q[i]) free_idx = IDX_W'(i);
            if (elig[i])   iss_idx  = IDX_W'(i);
        end
        enq_ready = ~&vld_q;
        iss_valid = |elig;
        iss_addr  = addr_q[iss_idx];
        enq_fire  = enq_valid && enq_ready;
        iss_fire  = iss_valid && iss_ack;
    end

    // Slot allocation, release and per-epoch flash clear of poison.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            io_q  <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                poison_q[i] <= '0;
                addr_q[i]   <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (enq_fire && free_idx == IDX_W'(i)) begin
                    vld_q[i]    <= 1'b1;
                    io_q[i]     <= enq_io;
                    addr_q[i]   <= enq_addr;
                    poison_q[i] <= enq_poison & ~clr;
                end else begin
                    poison_q[i] <= poison_q[i] & ~clr;
                    if (iss_fire && iss_idx == IDX_W'(i)) vld_q[i] <= 1'b0;
                end
            end
        end
    end

    p_io_after_drain_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && io_q[iss_idx]) |-> !any_pending);
    p_poison_never_grows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_q[0] && !$past(enq_fire && free_idx == '0)) |-> ((poison_q[0] & ~$past(poison_q[0])) == '0));
endmodule

// File: rtl/spt_issue_arb.sv
`timescale 1ns/1ps
// Shares the memory port between released demand requests and metadata
// fetches. Demand wins unless the metadata queue reports full. Nothing
// is offered while halted.
module spt_issue_arb #(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              dem_valid,
    input  logic [ADDR_W-1:0] dem_addr,
    input  logic              meta_valid,
    input  logic [ADDR_W-1:0] meta_addr,
    input  logic              meta_full,
    input  logic              halt,
    input  logic              mem_ready,
    output logic              mem_valid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_is_meta,
    output logic              dem_ack,
    output logic              meta_ready
);
    logic pick_meta;

    // Choose the source and form the handshakes.
    always_comb begin
        pick_meta   = meta_valid && (meta_full || !dem_valid);
        mem_valid   = !halt && (dem_valid || meta_valid);
        mem_is_meta = pick_meta;
        mem_addr    = pick_meta ? meta_addr : dem_addr;
        dem_ack     = mem_valid && mem_ready && !pick_meta;
        meta_ready  = mem_valid && mem_ready && pick_meta;
    end
endmodule

// File: rtl/spec_verif_tracker.sv
`timescale 1ns/1ps
// Top of the two-epoch speculative verification tracker: tags returns
// with the active epoch, retires results against the recorded epoch,
// pulses per-epoch clears and holds poisoned requests until cleared.
module spec_verif_tracker
    import spt_pkg::*;
#(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned QDEPTH  = 32,
    parameter int unsigned TAG_W   = 4,
    parameter int unsigned MIN_DUR = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ret_valid,
    input  logic [TAG_W-1:0]  ret_tag,
    output logic              ret_epoch,
    input  logic              vd_valid,
    input  logic [TAG_W-1:0]  vd_tag,
    input  logic              vd_ok,
    output logic [1:0]        epoch_clr,
    output logic              active_epoch,
    output logic              halt,
    input  logic              rq_valid,
    input  logic [ADDR_W-1:0] rq_addr,
    input  logic [1:0]        rq_poison,
    input  logic              rq_io,
    output logic              rq_ready,
    input  logic              meta_valid,
    input  logic [ADDR_W-1:0] meta_addr,
    input  logic              meta_full,
    output logic              meta_ready,
    output logic              mem_valid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_is_meta,
    input  logic              mem_ready
);
    localparam int unsigned CNT_W = TAG_W + 1;

    logic        cur_epoch, look_hit, look_epoch, any_pending;
    logic        dem_valid, dem_ack;
    logic [ADDR_W-1:0] dem_addr;
    epoch_mask_t clr;

    spt_tag_table #(.TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst_n(rst_n),
        .set_valid(ret_valid), .set_tag(ret_tag), .set_epoch(cur_epoch),
        .look_valid(vd_valid), .look_tag(vd_tag),
        .look_hit(look_hit), .look_epoch(look_epoch)
    );

    spt_epoch_ctrl #(.CNT_W(CNT_W), .MIN_DUR(MIN_DUR)) u_epoch (
        .clk(clk), .rst_n(rst_n),
        .inc(ret_valid), .dec_valid(vd_valid && look_hit), .dec_epoch(look_epoch),
        .fail(vd_valid && !vd_ok),
        .cur_epoch(cur_epoch), .clr(clr), .any_pending(any_pending), .halt(halt)
    );

    spt_hold_queue #(.ADDR_W(ADDR_W), .DEPTH(QDEPTH)) u_queue (
        .clk(clk), .rst_n(rst_n),
        .enq_valid(rq_valid), .enq_addr(rq_addr), .enq_poison(rq_poison),
        .enq_io(rq_io), .enq_ready(rq_ready),
        .clr(clr), .any_pending(any_pending),
        .iss_valid(dem_valid), .iss_addr(dem_addr), .iss_ack(dem_ack)
    );

    spt_issue_arb #(.ADDR_W(ADDR_W)) u_arb (
        .dem_valid(dem_valid), .dem_addr(dem_addr),
        .meta_valid(meta_valid), .meta_addr(meta_addr), .meta_full(meta_full),
        .halt(halt), .mem_ready(mem_ready),
        .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_is_meta(mem_is_meta),
        .dem_ack(dem_ack), .meta_ready(meta_ready)
    );

    // Export epoch state.
    always_comb begin
        ret_epoch    = cur_epoch;
        active_epoch = cur_epoch;
        epoch_clr    = clr;
    end

    p_halt_blocks_issue_r10: assert property (@(posedge clk) disable iff (!rst_n)
        halt |-> !mem_valid);
    p_meta_when_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && meta_valid && meta_full) |-> mem_is_meta);
    p_demand_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dem_valid && meta_valid && !meta_full && !halt) |-> !mem_is_meta);
endmodule

// File: tb/test_spec_verif_tracker.sv
`timescale 1ns/1ps
module test_spec_verif_tracker;
    localparam int ADDR_W = 32;
    localparam int TAG_W  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ret_valid = 0, vd_valid = 0, vd_ok = 1;
    logic [TAG_W-1:0] ret_tag = '0, vd_tag = '0;
    logic ret_epoch, active_epoch, halt, rq_ready, meta_ready, mem_valid, mem_is_meta;
    logic [1:0] epoch_clr;
    logic rq_valid = 0, rq_io = 0, meta_valid = 0, meta_full = 0, mem_ready = 0;
    logic [1:0] rq_poison = '0;
    logic [ADDR_W-1:0] rq_addr = '0, meta_addr = '0, mem_addr;

    int n_chk = 0, n_fail = 0;

    always #2 clk = ~clk;

    spec_verif_tracker i_spec_verif_tracker (
        .clk(clk), .rst_n(rst_n),
        .ret_valid(ret_valid), .ret_tag(ret_tag), .ret_epoch(ret_epoch),
        .vd_valid(vd_valid), .vd_tag(vd_tag), .vd_ok(vd_ok),
        .epoch_clr(epoch_clr), .active_epoch(active_epoch), .halt(halt),
        .rq_valid(rq_valid), .rq_addr(rq_addr), .rq_poison(rq_poison), .rq_io(rq_io),
        .rq_ready(rq_ready),
        .meta_valid(meta_valid), .meta_addr(meta_addr), .meta_full(meta_full),
        .meta_ready(meta_ready),
        .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_is_meta(mem_is_meta),
        .mem_ready(mem_ready)
    );

    // Arbitration vectors: {demand, meta_valid, meta_full, exp_valid, exp_meta}
    localparam logic [4:0] ARB_VEC [6] = '{
        5'b000_00, 5'b100_10, 5'b010_11, 5'b110_10, 5'b111_11, 5'b011_11
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    // Ends at a negedge with the requested epoch active.
    task automatic wait_epoch(input logic e);
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (active_epoch == e) return;
        end
        chk("R5 epoch never reached", {63'b0, active_epoch}, {63'b0, e});
    endtask

    task automatic enq(input logic [ADDR_W-1:0] a, input logic [1:0] p, input logic io);
        rq_valid = 1; rq_addr = a; rq_poison = p; rq_io = io;
        @(posedge clk);
        @(negedge clk);
        rq_valid = 0;
    endtask

    task automatic spec_ret(input logic [TAG_W-1:0] t, input logic e, input string req);
        ret_valid = 1; ret_tag = t;
        #0 chk(req, {63'b0, ret_epoch}, {63'b0, e});
        @(posedge clk);
        @(negedge clk);
        ret_valid = 0;
    endtask

    initial begin
        #(4 * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1 reset state
        chk("R1 epoch", {63'b0, active_epoch}, 0);
        chk("R1 halt", {63'b0, halt}, 0);
        chk("R1 clr", {62'b0, epoch_clr}, 0);
        chk("R1 mem_valid", {63'b0, mem_valid}, 0);
        chk("R1 rq_ready", {63'b0, rq_ready}, 1);

        // R5 first flip after the 9th edge with nothing pending
        begin
            int n = 0;
            for (int k = 1; k <= 20; k++) begin
                @(posedge clk); #1;
                if (active_epoch == 1'b1) begin n = k; break; end
            end
            chk("R5 flip edge", 64'(n), 9);
        end

        // R9 arbitration table
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (ARB_VEC[i][4]) enq(32'h100 + 32'(i), 2'b00, 1'b0);
            meta_valid = ARB_VEC[i][3];
            meta_full  = ARB_VEC[i][2];
            meta_addr  = 32'h200 + 32'(i);
            mem_ready  = 0;
            #1;
            chk("R9 valid", {63'b0, mem_valid}, {63'b0, ARB_VEC[i][1]});
            chk("R9 is_meta", {63'b0, mem_is_meta && mem_valid}, {63'b0, ARB_VEC[i][0]});
            if (ARB_VEC[i][1])
                chk("R9 addr", 64'(mem_addr),
                    ARB_VEC[i][0] ? 64'(32'h200 + 32'(i)) : 64'(32'h100 + 32'(i)));
            meta_valid = 0; meta_full = 0; mem_ready = 1;
            @(posedge clk);
            @(negedge clk);
            mem_ready = 0;
        end

        // R2 tagging in both epochs, R6 hold-open
        wait_epoch(1'b0);
        spec_ret(4'd3, 1'b0, "R2 tag epoch0");
        wait_epoch(1'b1);
        spec_ret(4'd4, 1'b1, "R2 tag epoch1");
        repeat (30) @(negedge clk);
        chk("R6 epoch held open", {63'b0, active_epoch}, 1);

        // R7/R8 held requests
        enq(32'hA0, 2'b01, 1'b0);
        enq(32'hB0, 2'b10, 1'b0);
        enq(32'hC0, 2'b00, 1'b1);
        #1 chk("R7 R8 all held", {63'b0, mem_valid}, 0);

        // R3 out of order: epoch1 result first, R4 clear only bit 1
        vd_valid = 1; vd_tag = 4'd4; vd_ok = 1;
        @(posedge clk); #1;
        chk("R3 R4 clr epoch1", {62'b0, epoch_clr}, 2'b10);
        @(negedge clk); vd_valid = 0;
        @(posedge clk); #1;
        chk("R4 single pulse", {62'b0, epoch_clr}, 0);
        chk("R7 B released", {63'b0, mem_valid}, 1);
        chk("R7 B addr", 64'(mem_addr), 64'h B0);
        @(negedge clk); mem_ready = 1;
        @(posedge clk); #1;
        chk("R7 R8 A and IO still held", {63'b0, mem_valid}, 0);
        @(negedge clk); mem_ready = 0;

        // epoch0 result
        vd_valid = 1; vd_tag = 4'd3;
        @(posedge clk); #1;
        chk("R3 R4 clr epoch0", {62'b0, epoch_clr}, 2'b01);
        @(negedge clk); vd_valid = 0;
        @(posedge clk); #1;
        chk("R7 A released", {63'b0, mem_valid}, 1);
        chk("R7 A addr lowest slot", 64'(mem_addr), 64'h A0);
        @(negedge clk); mem_ready = 1;
        @(posedge clk); #1;
        chk("R8 IO released after drain", 64'(mem_addr), 64'h C0);
        chk("R8 IO valid", {63'b0, mem_valid}, 1);
        @(posedge clk); #1;
        chk("R7 queue empty", {63'b0, mem_valid}, 0);
        @(negedge clk); mem_ready = 0;

        // R10 halt
        enq(32'hD0, 2'b00, 1'b0);
        #1 chk("R10 pre-halt offer", {63'b0, mem_valid}, 1);
        spec_ret(4'd5, active_epoch, "R2 tag before fail");
        vd_valid = 1; vd_tag = 4'd5; vd_ok = 0;
        @(posedge clk); #1;
        chk("R10 halt set", {63'b0, halt}, 1);
        chk("R10 port silent", {63'b0, mem_valid}, 0);
        @(negedge clk); vd_valid = 0; vd_ok = 1;
        repeat (5) @(negedge clk);
        chk("R10 halt sticky", {63'b0, halt}, 1);
        chk("R10 still silent", {63'b0, mem_valid}, 0);

        finish_up();
    end
endmodule